// File: doc/BRIEF.md
# Transmit frame padder and enable gate

This block sits in a byte-wide transmit stream between a packet source and a MAC output. Frames arrive with a ready/valid handshake and an end-of-frame marker. A frame may begin only while the transmit enable is high. Once a frame has started, it always runs to its end, even if the enable drops part way through. The pad enable and the FCS enable are taken at the first byte of each frame. When padding is on, a short frame is extended with zero bytes. When FCS insertion is on, a CRC-32 is appended. The output frame is then 64 bytes long.

A per-frame length limit bounds the number of bytes the block emits for one frame. Input beyond the limit is consumed and thrown away, and the frame is marked as errored on its last output byte. The block keeps two saturating counters, one for transmitted frames and one for transmitted bytes. Both advance only while the enable is high. The block also raises two one-cycle event pulses: one when a frame completes without error, and one when a counter reaches saturation.

Top module: `tx_pad_gate`

## Requirements
- R1: A frame starts only while `cfg_tx_en` is 1. While no frame is in progress and the enable is 0, `s_ready` and `m_valid` stay 0. Data bytes leave in arrival order, unchanged.
- R2: With `cfg_pad_en` set, a frame whose data ends short of 60 bytes (FCS on) or 64 bytes (FCS off) is extended with 0x00 bytes up to that length, so the output frame is 64 bytes.
- R3: With `cfg_fcs_en` set, four bytes follow the data and pad bytes, least significant byte first. They hold the inverted CRC-32 of those bytes: reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF. With the bit clear, nothing is appended.
- R4: Output bytes of one frame, FCS included, never exceed `cfg_max_len`. When the input is longer, the bytes beyond the limit are accepted and discarded up to `s_last`. `m_err` is 1 together with `m_last` on that frame only. `m_err` is never 1 without `m_last`.
- R5: Clearing `cfg_tx_en` during a frame does not shorten it. The frame completes in full, and the next frame waits until the enable returns.
- R6: While `m_valid` is 1 and `m_ready` is 0, the output byte is held. No byte is lost or repeated under any backpressure pattern.
- R7: `frame_cnt` increases by one for each completed output frame, and `byte_cnt` by one for each output byte. Both count only in cycles where `cfg_tx_en` is 1 and hold otherwise. Both are 0 after reset.
- R8: Each counter stops at 2^CNT_W-1. `evt_sat` pulses for one cycle, the cycle after a counter first reaches that value.
- R9: `evt_done` pulses for one cycle, the cycle after the last byte of a frame without error is accepted at the output.
- R10: After reset, `m_valid`, both counters and both events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_pad_en | input | 1 | Pad short frames |
| cfg_fcs_en | input | 1 | Append CRC-32 |
| cfg_max_len | input | LEN_W | Maximum output bytes per frame |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Last input byte of frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output sink ready |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Last output byte of frame |
| m_err | output | 1 | Frame was cut at the length limit |
| frame_cnt | output | CNT_W | Saturating frame counter |
| byte_cnt | output | CNT_W | Saturating byte counter |
| evt_done | output | 1 | Error-free frame completed |
| evt_sat | output | 1 | A counter just saturated |

## Verification
Frames are sent with every combination of pad and FCS enables. A 20-byte frame tells padding apart from plain pass-through. A 60-byte frame checks that padding stops exactly at the threshold. Frames longer than the minimum show that padding never adds bytes to a frame already long enough.

Inputs longer than the limit, with and without FCS, separate truncation and discard from normal ending. A frame exactly at the limit shows that the boundary itself is not flagged.

Random output backpressure shows that byte order and the CRC survive stalls in the data, pad and FCS phases. Dropping the enable mid-frame, then presenting a frame while the enable is 0, tells boundary gating apart from truncation and from a frozen counter. A long run of frames drives the byte counter into saturation.

// File: rtl/tx_pad_gate.sv
module tx_pad_gate #(
  parameter int LEN_W     = 14,
  parameter int CNT_W     = 32,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_tx_en,
  input  logic             cfg_pad_en,
  input  logic             cfg_fcs_en,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_last,
  output logic             m_err,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             evt_done,
  output logic             evt_sat
);
  localparam int FCS_N = 4;
  localparam logic [LEN_W-1:0] TGT_FCS = LEN_W'(MIN_FRAME - FCS_N);
  localparam logic [LEN_W-1:0] TGT_RAW = LEN_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] CMAX    = '1;

  typedef enum logic [2:0] {IDLE, DATA, PAD, FCS, DRAIN} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  st_t              st;
  logic [LEN_W-1:0] pos, max_q;
  logic [31:0]      crc;
  logic [1:0]       fidx;
  logic             pad_q, fcs_q, trunc_q;
  logic             busy;

  wire idle  = (st == IDLE);
  wire pad_e = idle ? cfg_pad_en  : pad_q;
  wire fcs_e = idle ? cfg_fcs_en  : fcs_q;
  wire [LEN_W-1:0] max_e = idle ? cfg_max_len : max_q;
  wire [LEN_W-1:0] ldata = fcs_e ? max_e - LEN_W'(FCS_N) : max_e;
  wire [LEN_W-1:0] tgt   = fcs_e ? TGT_FCS : TGT_RAW;
  wire [LEN_W-1:0] pos_n = pos + 1'b1;
  wire in_data  = (idle && cfg_tx_en) || (st == DATA);
  wire at_lim   = pos_n >= ldata;
  wire cut      = at_lim && !s_last;
  wire eod      = s_last || at_lim;
  wire need_pad = pad_e && s_last && (pos_n < tgt);
  wire [31:0] fcs_word = ~crc;
  wire [31:0] crc_upd  = crc_step(idle ? 32'hFFFFFFFF : crc, m_data);
  wire s_fire = s_valid && s_ready;
  wire m_fire = m_valid && m_ready;

  assign busy = !idle;

  always_comb begin
    s_ready = 1'b0; m_valid = 1'b0; m_data = 8'd0; m_last = 1'b0; m_err = 1'b0;
    case (st)
      IDLE, DATA: begin
        m_valid = s_valid && in_data;
        s_ready = m_ready && in_data;
        m_data  = s_data;
        m_last  = eod && !need_pad && !fcs_e;
        m_err   = cut && !fcs_e;
      end
      PAD: begin
        m_valid = 1'b1;
        m_last  = (pos_n == tgt) && !fcs_q;
      end
      FCS: begin
        m_valid = 1'b1;
        m_data  = fcs_word[fidx*8 +: 8];
        m_last  = (fidx == 2'd3);
        m_err   = trunc_q && m_last;
      end
      DRAIN: s_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; pos <= '0; crc <= '1; fidx <= '0;
      pad_q <= 1'b0; fcs_q <= 1'b0; trunc_q <= 1'b0; max_q <= '0;
    end else begin
      case (st)
        IDLE, DATA: if (s_fire) begin
          if (idle) begin pad_q <= cfg_pad_en; fcs_q <= cfg_fcs_en; max_q <= cfg_max_len; end
          crc <= crc_upd; pos <= pos_n; trunc_q <= cut;
          if (!eod)          st <= DATA;
          else if (need_pad) st <= PAD;
          else begin
            pos <= '0;
            st  <= cut ? DRAIN : (fcs_e ? FCS : IDLE);
          end
        end
        PAD: if (m_fire) begin
          crc <= crc_upd; pos <= pos_n;
          if (pos_n == tgt) begin pos <= '0; st <= fcs_q ? FCS : IDLE; end
        end
        FCS: if (m_fire) begin
          fidx <= fidx + 1'b1;
          if (fidx == 2'd3) st <= IDLE;
        end
        DRAIN: if (s_valid && s_last) st <= fcs_q ? FCS : IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire inc_b = m_fire && cfg_tx_en && (byte_cnt != CMAX);
  wire inc_f = m_fire && m_last && cfg_tx_en && (frame_cnt != CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0; byte_cnt <= '0; evt_done <= 1'b0; evt_sat <= 1'b0;
    end else begin
      if (inc_b) byte_cnt  <= byte_cnt + 1'b1;
      if (inc_f) frame_cnt <= frame_cnt + 1'b1;
      evt_done <= m_fire && m_last && !m_err;
      evt_sat  <= (inc_b && byte_cnt == CMAX - 1'b1) || (inc_f && frame_cnt == CMAX - 1'b1);
    end
  end
endmodule

// File: rtl/tx_pad_gate_chk.sv
module tx_pad_gate_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_tx_en,
  input logic             busy,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             m_last,
  input logic             m_err,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             evt_done
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_tx_en) |-> (!s_ready && !m_valid));

  assert_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> m_last);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |=> ($stable(frame_cnt) && $stable(byte_cnt)));

  assert_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt == {CNT_W{1'b1}}) |=> (byte_cnt == {CNT_W{1'b1}}));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(m_valid && m_ready && m_last && !m_err));
endmodule

bind tx_pad_gate tx_pad_gate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .busy(busy),
  .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_last(m_last), .m_err(m_err), .frame_cnt(frame_cnt), .byte_cnt(byte_cnt),
  .evt_done(evt_done)
);

// File: tb/tx_pad_gate_tb_top.sv
module tx_pad_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 14;
  localparam int CNT_W = 10;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic cfg_tx_en = 0, cfg_pad_en = 0, cfg_fcs_en = 0;
  logic [LEN_W-1:0] cfg_max_len = 14'd9250;
  logic s_valid = 0, s_last = 0, m_ready = 1;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_last, m_err, evt_done, evt_sat;
  logic [7:0] m_data;
  logic [CNT_W-1:0] frame_cnt, byte_cnt;

  tx_pad_gate #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";
  logic [9:0] exp_q[$];
  int m_frames = 0, m_bytes = 0;
  bit m_done = 0, m_sat = 0, bp = 0, run = 0;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc32(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) for (int i = 0; i < 8; i++) begin
      bit fb = c[0] ^ b[k][i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return ~c;
  endfunction

  task automatic push_exp(input logic [7:0] d[$]);
    logic [7:0] o[$];
    int lim = cfg_fcs_en ? int'(cfg_max_len) - 4 : int'(cfg_max_len);
    int tgt = cfg_fcs_en ? 60 : 64;
    bit tr = d.size() > lim;
    logic [31:0] c;
    for (int i = 0; i < d.size() && i < lim; i++) o.push_back(d[i]);
    if (cfg_pad_en && !tr) while (o.size() < tgt) o.push_back(8'h00);
    if (cfg_fcs_en) begin
      c = crc32(o);
      for (int i = 0; i < 4; i++) o.push_back(c[8*i +: 8]);
    end
    for (int i = 0; i < o.size(); i++)
      exp_q.push_back({(i == o.size()-1) && tr, i == o.size()-1, o[i]});
  endtask

  task automatic send_frame(input int len, input int seed);
    logic [7:0] d[$];
    for (int i = 0; i < len; i++) d.push_back(8'(seed + i * 7));
    push_exp(d);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = d[i]; s_last = (i == len - 1);
      do @(posedge clk); while (!s_ready);
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) m_ready = bp ? 1'($urandom % 2) : 1'b1;

  always @(posedge clk) if (rst_n) begin
    logic [9:0] e;
    m_done = 0; m_sat = 0;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) chk(0, tag, "unexpected output byte", m_data, -1);
      else begin
        e = exp_q.pop_front();
        chk(m_data == e[7:0], tag, "m_data", m_data, e[7:0]);
        chk(m_last == e[8], tag, "m_last", m_last, e[8]);
        chk(m_err == e[9], "R4", "m_err", m_err, e[9]);
        if (cfg_tx_en) begin
          if (m_bytes < CMAX) begin m_bytes++; if (m_bytes == CMAX) m_sat = 1; end
          if (e[8] && m_frames < CMAX) begin m_frames++; if (m_frames == CMAX) m_sat = 1; end
        end
        m_done = e[8] && !e[9];
      end
    end
  end

  always @(negedge clk) if (run) begin
    chk(int'(byte_cnt) == m_bytes, "R7", "byte_cnt", byte_cnt, m_bytes);
    chk(int'(frame_cnt) == m_frames, "R7", "frame_cnt", frame_cnt, m_frames);
    chk(evt_done == m_done, "R9", "evt_done", evt_done, m_done);
    chk(evt_sat == m_sat, "R8", "evt_sat", evt_sat, m_sat);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "R1", "watchdog expired", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v[$];
    v = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(crc32(v) == 32'hCBF43926, "R3", "bench crc reference", 0, 1);
    repeat (3) @(negedge clk);
    chk(!m_valid && !s_ready && frame_cnt == 0 && byte_cnt == 0 && !evt_done && !evt_sat,
        "R10", "reset state", m_valid, 0);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    s_valid = 1; s_data = 8'hAA; s_last = 1;
    repeat (4) begin @(negedge clk); chk(!s_ready && !m_valid, "R1", "idle while disabled", s_ready, 0); end
    s_valid = 0; s_last = 0;

    cfg_tx_en = 1;
    tag = "R1"; send_frame(70, 1);   wait_idle();
    cfg_pad_en = 1; cfg_fcs_en = 1;
    tag = "R2"; send_frame(20, 3);   wait_idle();
    tag = "R2"; send_frame(60, 4);   wait_idle();
    tag = "R3"; send_frame(100, 5);  wait_idle();
    cfg_pad_en = 0;
    tag = "R3"; send_frame(10, 6);   wait_idle();
    cfg_pad_en = 1; cfg_fcs_en = 0;
    tag = "R2"; send_frame(10, 7);   wait_idle();
    cfg_pad_en = 0;
    tag = "R1"; send_frame(10, 8);   wait_idle();

    cfg_fcs_en = 1; cfg_pad_en = 1; cfg_max_len = 14'd80;
    tag = "R4"; send_frame(100, 9);  send_frame(30, 10); wait_idle();
    cfg_max_len = 14'd104;
    tag = "R4"; send_frame(100, 11); wait_idle();
    cfg_fcs_en = 0; cfg_pad_en = 0; cfg_max_len = 14'd70;
    tag = "R4"; send_frame(90, 12);  send_frame(5, 13); wait_idle();
    cfg_max_len = 14'd9250;

    bp = 1; cfg_fcs_en = 1; cfg_pad_en = 1;
    tag = "R6";
    for (int i = 0; i < 6; i++) send_frame(5 + i * 23, 20 + i);
    wait_idle();

    tag = "R5";
    fork
      send_frame(200, 40);
      begin repeat (30) @(negedge clk); cfg_tx_en = 0; end
    join
    wait_idle();
    chk(exp_q.size() == 0, "R5", "frame finished after disable", exp_q.size(), 0);
    fork
      send_frame(25, 41);
      begin
        repeat (20) begin @(negedge clk); chk(!s_ready && !m_valid, "R5", "blocked while disabled", s_ready, 0); end
        cfg_tx_en = 1;
      end
    join
    wait_idle();
    bp = 0;

    cfg_pad_en = 0; cfg_fcs_en = 0;
    tag = "R8";
    for (int i = 0; i < 18; i++) send_frame(64, 60 + i);
    wait_idle();
    chk(int'(byte_cnt) == CMAX, "R8", "byte counter saturated", byte_cnt, CMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule